// File: doc/BRIEF.md
# MDIO management command controller

This block is a management-bus master for talking to an external PHY. Software writes one 32-bit command word. The word holds an opcode, a 5-bit PHY address, a 5-bit register address and a 16-bit data value. The block then plays out one serial management frame on the MDC clock and MDIO data lines.

When the frame finishes, the block raises a ready flag in the same word. If the word's interrupt-enable bit is set, it also raises an interrupt. For a read, the 16 bits returned by the PHY replace the data field, and software collects them from there.

The MDIO line is not an inout port. It is brought out as an output value plus an output enable, so that the pad ring builds the tri-state driver. MDC is derived from the system clock by a divider whose half period is a parameter. MDIO only changes while MDC is low.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_word` reads 0, and `irq`, `mdc` and `mdio_oe` are 0.
- R2: A write accepted while idle loads the command fields, read back in `cmd_word` at these positions:
  - bit 29: interrupt enable
  - bit 28: ready
  - bits 27:26: opcode
  - bits 25:21: PHY address
  - bits 20:16: register address
  - bits 15:0: data

  Bits 31:30 always read 0. For a valid opcode, ready reads 0 from the cycle after the write, whatever value was written to bit 28.
- R3: Opcode 01 (write) sends 64 bits MSB first, with `mdio_oe` high throughout. The bits are, in order:
  - 32 ones
  - 01
  - the opcode
  - the PHY address
  - the register address
  - 10
  - the 16 data bits
- R4: Opcode 10 (read) drives the first 46 bits of the same frame, with the opcode bits reading 10. It then holds `mdio_oe` low for the 2 turnaround bits and the 16 data bits. It samples `mdio_i` at the rising MDC edge of each data bit, MSB first, and stores the result in bits 15:0.
- R5: While a frame runs, MDC has a period of 2·MDC_HALF system clocks. Its first rising edge comes MDC_HALF clocks after the accepting edge. MDC is low when idle. `mdio_o` and `mdio_oe` never change while MDC is high.
- R6: Ready is set 128·MDC_HALF clocks after the accepting edge, after 64 MDC periods. At that point `mdc` and `mdio_oe` are low.
- R7: Opcodes 00 and 11 set ready in the cycle after the write. They produce no MDC edge and no MDIO drive.
- R8: A write arriving while a frame runs is ignored. The fields, the frame bits and the completion time are all unaffected.
- R9: `irq` is high exactly while interrupt enable and ready are both 1. It falls when a write clears ready (a new valid command) or clears interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word write value |
| cmd_word | output | 32 | Command/status word read-back |
| irq | output | 1 | End-of-cycle interrupt |
| mdc | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with MDC_HALF = 2, so that one frame lasts 256 clocks. At that length it can sweep all 32 PHY addresses in both write and read frames, with every register address value covered and data patterns derived from the loop index. Each frame is checked bit by bit against a frame assembled in the bench, along with its MDC period and completion latency. The bench also covers both reserved opcodes, writes that land mid-frame, and every way the interrupt can be set and cleared.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int MDC_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] cmd_word,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam int FRAME_BITS = 64;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_BIT = BW'(46);
  localparam logic [BW-1:0] DATA_BIT = BW'(48);
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  logic          ie, rdy, busy, mdc_q, oe_q;
  logic [1:0]    op;
  logic [4:0]    phy, ra;
  logic [15:0]   dat;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [FRAME_BITS-1:0] sh;

  wire           wr_op_ok = (wr_data[27:26] == OP_WR) || (wr_data[27:26] == OP_RD);
  wire           accept   = wr_en && !busy;
  wire           is_rd    = (op == OP_RD);
  wire           tick     = (cnt == CW'(MDC_HALF - 1));
  wire           rise     = busy && tick && !mdc_q;
  wire           fall     = busy && tick && mdc_q;
  wire [BW-1:0]  nb       = bidx + BW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      rdy   <= 1'b0;
      busy  <= 1'b0;
      mdc_q <= 1'b0;
      oe_q  <= 1'b0;
      op    <= '0;
      phy   <= '0;
      ra    <= '0;
      dat   <= '0;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
    end else if (accept) begin
      ie    <= wr_data[29];
      op    <= wr_data[27:26];
      phy   <= wr_data[25:21];
      ra    <= wr_data[20:16];
      dat   <= wr_data[15:0];
      rdy   <= !wr_op_ok;
      busy  <= wr_op_ok;
      oe_q  <= wr_op_ok;
      mdc_q <= 1'b0;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= {32'hFFFF_FFFF, 2'b01, wr_data[27:26], wr_data[25:21],
                wr_data[20:16], 2'b10, wr_data[15:0]};
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick) mdc_q <= !mdc_q;
      if (rise && is_rd && bidx >= DATA_BIT) dat <= {dat[14:0], mdio_i};
      if (fall) begin
        if (bidx == LAST_BIT) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
          oe_q <= 1'b0;
        end else begin
          bidx <= nb;
          sh   <= {sh[FRAME_BITS-2:0], 1'b0};
          if (is_rd && nb >= TA_BIT) oe_q <= 1'b0;
        end
      end
    end
  end

  assign cmd_word = {2'b00, ie, rdy, op, phy, ra, dat};
  assign irq      = ie & rdy;
  assign mdc      = mdc_q;
  assign mdio_oe  = oe_q;
  assign mdio_o   = oe_q & sh[FRAME_BITS-1];

  a_r5_mdio_holds_while_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r5_mdc_low_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_word[28] |-> !mdc);

  a_r6_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_word[28]) |-> (!mdio_oe && !mdc));

  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_op_ok) |=> (cmd_word[28] && !mdio_oe && !mdc));

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ({cmd_word[29], cmd_word[27:16]} == $past({cmd_word[29], cmd_word[27:16]})));

  a_r9_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        mdio_i = 1'b0;
  logic [31:0] cmd_word;
  logic        irq, mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;

  mdio_cmd_ctrl #(.MDC_HALF(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_word(cmd_word), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] dat, input logic [15:0] rdpat,
                       input bit ie, input bit intrude);
    logic [63:0] got_o, got_oe, exp;
    int rises, n, first_n, last_n;
    bit pm;
    bit rd;
    rd = (op == 2'b10);
    got_o = '0;
    got_oe = '0;
    rises = 0;
    first_n = 0;
    last_n = 0;
    mdio_i = 1'b0;
    exp = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, dat};
    wr({2'b11, ie, 1'b1, op, phy, ra, dat});
    n = 1;
    chk(cmd_word == {2'b00, ie, 1'b0, op, phy, ra, dat}, "R2 field readback", 64'(cmd_word),
        64'({2'b00, ie, 1'b0, op, phy, ra, dat}));
    chk(irq == 1'b0, "R9 irq cleared by new command", 64'(irq), 64'd0);
    pm = mdc;
    while (!cmd_word[28] && n < 2000) begin
      if (mdc && !pm) begin
        if (rises < 64) begin
          got_o[63-rises] = mdio_o;
          got_oe[63-rises] = mdio_oe;
        end
        if (rises == 0) first_n = n;
        last_n = n;
        rises++;
        if (rises >= 48 && rises < 64) mdio_i = rdpat[63-rises];
        if (intrude && rises == 10) begin
          wr_en = 1'b1;
          wr_data = 32'h3FFF_FFFF;
        end
      end
      pm = mdc;
      @(negedge clk);
      n++;
      wr_en = 1'b0;
    end
    chk(n == 128*H + 1, "R6 completion latency", 64'(n), 64'(128*H + 1));
    chk(rises == 64 && first_n == H + 1 && last_n == H + 1 + 63*2*H, "R5 MDC timing",
        64'({rises[15:0], first_n[15:0], last_n[15:0]}),
        64'({16'd64, 16'(H + 1), 16'(H + 1 + 63*2*H)}));
    chk(!mdc && !mdio_oe, "R6 bus released at done", 64'({mdc, mdio_oe}), 64'd0);
    chk(irq == ie, "R9 irq follows enable at done", 64'(irq), 64'(ie));
    if (!rd) begin
      chk(got_o == exp, intrude ? "R8 write frame unaffected" : "R3 write frame bits", got_o, exp);
      chk(got_oe == '1, "R3 write frame drive", got_oe, '1);
      chk(cmd_word == {2'b00, ie, 1'b1, op, phy, ra, dat}, intrude ? "R8 fields kept" : "R2 fields after write",
          64'(cmd_word), 64'({2'b00, ie, 1'b1, op, phy, ra, dat}));
    end else begin
      chk(got_o[63:18] == exp[63:18], intrude ? "R8 read header unaffected" : "R4 read header bits",
          64'(got_o[63:18]), 64'(exp[63:18]));
      chk(got_oe == {{46{1'b1}}, 18'd0}, "R4 read drive pattern", got_oe, {{46{1'b1}}, 18'd0});
      chk(cmd_word == {2'b00, ie, 1'b1, op, phy, ra, rdpat}, intrude ? "R8 fields kept" : "R4 read data stored",
          64'(cmd_word), 64'({2'b00, ie, 1'b1, op, phy, ra, rdpat}));
    end
  endtask

  task automatic reserved(input logic [1:0] op, input bit ie);
    bit moved;
    wr({2'b00, ie, 1'b0, op, 5'h11, 5'h03, 16'hBEEF});
    chk(cmd_word == {2'b00, ie, 1'b1, op, 5'h11, 5'h03, 16'hBEEF}, "R7 reserved sets ready",
        64'(cmd_word), 64'({2'b00, ie, 1'b1, op, 5'h11, 5'h03, 16'hBEEF}));
    chk(irq == ie, "R9 irq on reserved completion", 64'(irq), 64'(ie));
    moved = 1'b0;
    for (int k = 0; k < 6*H; k++) begin
      if (mdc || mdio_oe) moved = 1'b1;
      @(negedge clk);
    end
    chk(!moved, "R7 no bus activity", 64'(moved), 64'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_word == 32'd0, "R1 reset word", 64'(cmd_word), 64'd0);
    chk({irq, mdc, mdio_oe} == 3'b000, "R1 reset outputs", 64'({irq, mdc, mdio_oe}), 64'd0);
    for (int i = 0; i < 32; i++) begin
      frame(2'b01, 5'(i), 5'(31 - i), 16'(i * 16'h0841) ^ 16'hA5C3, 16'd0, i[0], i == 5);
      frame(2'b10, 5'(i), 5'(i) ^ 5'h0A, 16'h1234, ~16'(i * 16'h1357), !i[0], i == 7);
    end
    reserved(2'b00, 1'b1);
    reserved(2'b11, 1'b1);
    frame(2'b10, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b1, 1'b0);
    reserved(2'b11, 1'b0);
    chk(irq == 1'b0, "R9 irq cleared by enable off", 64'(irq), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule